// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage

This block is one stage of a pipelined radix-2 decimation-in-frequency FFT that takes one complex sample per accepted beat. Incoming samples are paired with the sample that arrived N accepted beats earlier, where N is a power of two. A feedback loop that holds exactly N samples does the pairing. A counter of accepted beats divides the stream into blocks of 2N. In the first half of each block the stage parks the new samples in the loop and emits what the loop returns. In the second half it emits the sums of the pairs and sends the differences back into the loop. Those differences come out during the first half of the next block.

Two parameters can each move one register of the loop delay into the butterfly: one on the operand coming back from the loop and one on the difference going into it. The external delay line is shortened by the same amount, so the port behaviour does not change. This lets long first stages be retimed without touching anything around them.

Both sides of the stage are streams. The stage cannot hold back data by itself, so `in_ready` follows `out_ready` in the same cycle. A beat is accepted, and the loop and counter advance, only in a cycle where `in_valid` and `out_ready` are both high. In any other cycle all state holds. `out_valid` is asserted in the same cycle as `in_valid` once the stage has filled. While `out_ready` is low, the presented output stays a pure function of the held state and of the current input.

Top module: `sdf_r2_stage`

## Requirements
- R1: The block phase is set by the count of accepted beats modulo 2N. Beats 0 to N-1 of each block are the pass phase and beats N to 2N-1 are the combine phase.
- R2: In the combine phase, for the current input x[i], the output is x[i-N] + x[i], computed separately for the real and imaginary parts.
- R3: In a pass phase, for accepted index i ≥ 2N, the output is x[i-2N] − x[i-N]. This is the difference stored one half-block earlier.
- R4: State advances only when `in_valid` and `out_ready` are both high. A stall of any length leaves the pairing and the phase unchanged.
- R5: `in_ready` equals `out_ready` in every cycle, and `out_valid` is never high without `in_valid`.
- R6: After reset, `out_valid` stays low for the first N accepted beats. From then on it equals `in_valid`.
- R7: Any legal choice of the two retiming parameters (each 0 or 1, with a sum no larger than N) gives the same port behaviour as having none.
- R8: The outputs are W+1 bits wide and signed two's complement. Sums and differences of full-scale inputs, including the most negative value, are exact.
- R9: A synchronous reset in mid-stream restarts the phase count and the fill, so pairing starts again from the next accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can accept; mirrors out_ready |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output |
| out_re | output | W+1 | Output real part, signed |
| out_im | output | W+1 | Output imaginary part, signed |

## Verification
The bench uses random gaps on both `in_valid` and `out_ready`. A stage that advanced on a valid beat that was not accepted would pair samples from the wrong distance, and its sums would drift away from the model at once. The same stream runs through three instances: no retiming, both retimings, and N = 1 with output retiming. A loop that is one register too long or too short shows up as mismatched pairs.

Full-scale inputs of both signs target a stage that drops the extra output bit, because such a stage would wrap the sum of two minimum values. A reset in the middle of a block targets a counter or fill flag that survives reset. That fault would give early `out_valid` and misaligned pairs.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic {
    PH_PASS    = 1'b0,
    PH_COMBINE = 1'b1
  } sdf_phase_e;
endpackage

// File: rtl/sdf_gated_delay.sv
module sdf_gated_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, en};
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else if (en) begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sdf_phase_ctl.sv
module sdf_phase_ctl
  import sdf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output sdf_phase_e phase,
  output logic       primed
);
  localparam int LOG2N = $clog2(N);
  localparam int CW    = LOG2N + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(N - 1)) primed <= 1'b1;
    end
  end

  assign phase = cnt[CW-1] ? PH_COMBINE : PH_PASS;
endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly
  import sdf_pkg::*;
#(
  parameter int W  = 8,
  parameter int DA = 0,
  parameter int DD = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  sdf_phase_e        phase,
  input  logic signed [W:0] fb_re,
  input  logic signed [W:0] fb_im,
  input  logic signed [W-1:0] nw_re,
  input  logic signed [W-1:0] nw_im,
  output logic signed [W:0] sum_re,
  output logic signed [W:0] sum_im,
  output logic signed [W:0] dif_re,
  output logic signed [W:0] dif_im
);
  localparam int OW = W + 1;

  logic [2*OW-1:0] a_pk, dpre_pk, dpost_pk;
  logic signed [W:0] a_re, a_im, b_re, b_im, dp_re, dp_im;

  sdf_gated_delay #(.W(2*OW), .DEPTH(DA)) u_a_dly (
    .clk(clk), .rst(rst), .en(adv), .d({fb_re, fb_im}), .q(a_pk)
  );

  assign a_re = a_pk[2*OW-1:OW];
  assign a_im = a_pk[OW-1:0];
  assign b_re = {nw_re[W-1], nw_re};
  assign b_im = {nw_im[W-1], nw_im};

  always_comb begin
    if (phase == PH_COMBINE) begin
      sum_re = a_re + b_re;
      sum_im = a_im + b_im;
      dp_re  = a_re - b_re;
      dp_im  = a_im - b_im;
    end else begin
      sum_re = a_re;
      sum_im = a_im;
      dp_re  = b_re;
      dp_im  = b_im;
    end
  end

  assign dpre_pk = {dp_re, dp_im};

  sdf_gated_delay #(.W(2*OW), .DEPTH(DD)) u_d_dly (
    .clk(clk), .rst(rst), .en(adv), .d(dpre_pk), .q(dpost_pk)
  );

  assign dif_re = dpost_pk[2*OW-1:OW];
  assign dif_im = dpost_pk[OW-1:0];
endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_pkg::*;
#(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int DA = 0,
  parameter int DD = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W:0]   out_re,
  output logic signed [W:0]   out_im
);
  localparam int OW = W + 1;
  localparam int FB = N - DA - DD;

  logic       adv, primed;
  sdf_phase_e phase;
  logic signed [W:0] fb_re, fb_im, dif_re, dif_im;
  logic [2*OW-1:0]   fb_pk;

  assign in_ready  = out_ready;
  assign adv       = in_valid & out_ready;
  assign out_valid = in_valid & primed;

  sdf_phase_ctl #(.N(N)) u_ctl (
    .clk(clk), .rst(rst), .adv(adv), .phase(phase), .primed(primed)
  );

  sdf_butterfly #(.W(W), .DA(DA), .DD(DD)) u_bf (
    .clk(clk), .rst(rst), .adv(adv), .phase(phase),
    .fb_re(fb_re), .fb_im(fb_im), .nw_re(in_re), .nw_im(in_im),
    .sum_re(out_re), .sum_im(out_im), .dif_re(dif_re), .dif_im(dif_im)
  );

  sdf_gated_delay #(.W(2*OW), .DEPTH(FB)) u_loop (
    .clk(clk), .rst(rst), .en(adv), .d({dif_re, dif_im}), .q(fb_pk)
  );

  assign fb_re = fb_pk[2*OW-1:OW];
  assign fb_im = fb_pk[OW-1:0];
endmodule

// File: rtl/sdf_r2_stage_chk.sv
module sdf_r2_stage_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_ready,
  input logic out_valid,
  input logic phase_bit
);
  localparam int CW = $clog2(N) + 1;

  logic [CW-1:0] seen;
  logic          full;
  logic          acc;

  assign acc = in_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      full <= 1'b0;
    end else if (acc) begin
      seen <= seen + 1'b1;
      if (seen == CW'(N - 1)) full <= 1'b1;
    end
  end

  // R1: phase follows the count of accepted beats modulo 2N
  p_phase_count_r1: assert property (@(posedge clk) disable iff (rst)
    phase_bit == (seen >= CW'(N)));

  // R4: no accept, no phase change
  p_hold_on_stall_r4: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(phase_bit));

  // R5: output valid only with an input
  p_valid_needs_input_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_valid);

  // R6: silent until N beats have entered
  p_quiet_until_full_r6: assert property (@(posedge clk) disable iff (rst)
    !full |-> !out_valid);

  // R6: once filled, every input beat is presented
  p_valid_after_full_r6: assert property (@(posedge clk) disable iff (rst)
    (full && in_valid) |-> out_valid);
endmodule

bind sdf_r2_stage sdf_r2_stage_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
  .out_valid(out_valid), .phase_bit(phase)
);

// File: tb/sdf_r2_stage_tb_top.sv
module sdf_r2_stage_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [W-1:0] in_re = '0;
  logic signed [W-1:0] in_im = '0;

  logic ir0, ov0, ir1, ov1, ir2, ov2;
  logic signed [W:0] re0, im0, re1, im1, re2, im2;

  always #5 clk = ~clk;

  sdf_r2_stage #(.W(W), .N(4), .DA(0), .DD(0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir0),
    .in_re(in_re), .in_im(in_im), .out_valid(ov0), .out_ready(out_ready),
    .out_re(re0), .out_im(im0));

  sdf_r2_stage #(.W(W), .N(4), .DA(1), .DD(1)) dut_rt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir1),
    .in_re(in_re), .in_im(in_im), .out_valid(ov1), .out_ready(out_ready),
    .out_re(re1), .out_im(im1));

  sdf_r2_stage #(.W(W), .N(1), .DA(0), .DD(1)) dut_n1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir2),
    .in_re(in_re), .in_im(in_im), .out_valid(ov2), .out_ready(out_ready),
    .out_re(re2), .out_im(im2));

  int hist_re [4096];
  int hist_im [4096];
  int acc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string ptag = "";

  task automatic check_one(string nm, int n, string dtag, logic ir, logic ov,
                           logic signed [W:0] ore, logic signed [W:0] oim);
    bit ev;
    int er, ei, p, cr, ci;
    checks++;
    if (ir !== out_ready) begin
      errors++;
      $display("FAIL R5 %s in_ready=%0b exp %0b", nm, ir, out_ready);
    end
    ev = in_valid && (acc >= n);
    checks++;
    if (ov !== ev) begin
      errors++;
      $display("FAIL R6 %s%s out_valid=%0b exp %0b (acc %0d)", nm, ptag, ov, ev, acc);
    end
    if (ev) begin
      cr = int'(in_re);
      ci = int'(in_im);
      p  = acc % (2 * n);
      if (p >= n) begin
        er = hist_re[acc-n] + cr;
        ei = hist_im[acc-n] + ci;
      end else begin
        er = hist_re[acc-2*n] - hist_re[acc-n];
        ei = hist_im[acc-2*n] - hist_im[acc-n];
      end
      checks++;
      if (int'(ore) != er || int'(oim) != ei) begin
        errors++;
        $display("FAIL %s%s %s re/im=%0d/%0d exp %0d/%0d", (p >= n) ? "R2" : "R3",
                 {dtag, ptag}, nm, int'(ore), int'(oim), er, ei);
      end
    end
  endtask

  task automatic step(bit r, bit v, bit rdy, int xr, int xi);
    @(posedge clk);
    #1;
    rst       = r;
    in_valid  = v;
    out_ready = rdy;
    in_re     = W'(xr);
    in_im     = W'(xi);
    @(negedge clk);
    if (!r) begin
      check_one("dut_i",  4, "",    ir0, ov0, re0, im0);
      check_one("dut_rt", 4, " R7", ir1, ov1, re1, im1);
      check_one("dut_n1", 1, " R7", ir2, ov2, re2, im2);
      if (v && rdy && acc < 4096) begin
        hist_re[acc] = xr;
        hist_im[acc] = xi;
        acc++;
      end
    end else begin
      acc = 0;
    end
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(255, 0)) - 128;
  endfunction

  initial begin
    void'($urandom(7));
    for (int k = 0; k < 3; k++) step(1, 0, 1, 0, 0);
    // reset state: input present but nothing filled (R6)
    ptag = " R6";
    step(0, 1, 0, 11, -3);
    step(0, 0, 1, 0, 0);
    // dense stream, then random gaps on both sides (R4)
    ptag = "";
    for (int k = 0; k < 40; k++) step(0, 1, 1, rnd_s(), rnd_s());
    ptag = " R4";
    for (int k = 0; k < 400; k++)
      step(0, ($urandom_range(3, 0) != 0), ($urandom_range(4, 0) != 0), rnd_s(), rnd_s());
    // full-scale extremes (R8)
    ptag = " R8";
    for (int k = 0; k < 48; k++) begin
      int v = ((k / 3) % 2 == 0) ? -128 : 127;
      step(0, 1, 1, v, (k % 5 == 0) ? 127 : -128);
    end
    // mid-block reset and restart (R9)
    ptag = " R9";
    for (int k = 0; k < 5; k++) step(0, 1, 1, rnd_s(), rnd_s());
    step(1, 1, 1, 0, 0);
    for (int k = 0; k < 120; k++)
      step(0, ($urandom_range(2, 0) != 0), ($urandom_range(3, 0) != 0), rnd_s(), rnd_s());
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule